// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block places a tiny direct-mapped, write-back cache between a processor request port and a slow, word-addressed main memory. The memory holds 32 byte-wide words. The cache holds 8 one-word lines. Each line keeps a valid flag, a dirty flag, a tag and one data byte. Every accepted access is classified as a read hit, read miss, write hit or write miss, and this class is reported along with a one-cycle completion pulse.

A miss that lands on a modified line runs in two steps. First the old word is written back to memory at the address rebuilt from its stored tag and the index. Only then is the miss served. A read miss fetches the word from memory and installs it clean. A write miss installs the new byte as a dirty line and never reads memory, because a line holds exactly one word. The memory port uses a request/ready handshake and accepts any latency. While the controller is busy it does not accept new commands.

Top module: `wbc_top`

## Requirements
- R1: The 5-bit address splits into a tag in bits [4:3] and an index in bits [2:0]. For example, address 0x17 selects line 7 with tag 2, so 0x17 and 0x0F compete for the same line.
- R2: A read whose line is valid with a matching tag completes as kind 0 (read hit). It returns the cached byte and makes no memory request.
- R3: A write whose line is valid with a matching tag completes as kind 2 (write hit). It replaces the cached byte, marks the line dirty and makes no memory request.
- R4: A read miss on a clean or invalid line issues one memory read at the requested address. It returns that word, installs it clean and completes as kind 1 (read miss).
- R5: A miss on a valid dirty line first issues a memory write of the stored byte to address {stored tag, index}. Any other memory access for that miss comes after this write.
- R6: A write miss issues no memory read. It installs the new byte as a valid dirty line and completes as kind 3 (write miss).
- R7: Command code 5 is a read and code 6 is a write. Any other code is dropped: no busy, no completion pulse, no memory access and no change to cache contents.
- R8: Reset clears every valid and dirty flag and leaves busy, done and the memory request low. The first access to each line after reset therefore misses.
- R9: Once raised, the memory request holds its address, direction and write data steady until a cycle with ready high. The request completes on that clock edge, whatever the latency.
- R10: Each accepted command yields exactly one single-cycle done pulse, with busy high from acceptance through that pulse. A command presented while busy is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Command present |
| cpu_op | input | 4 | Command code (5 read, 6 write) |
| cpu_addr | input | 5 | Word address |
| cpu_wdata | input | 8 | Write byte |
| cpu_busy | output | 1 | A command is in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with done |
| cpu_kind | output | 2 | Access class: 0 RH, 1 RM, 2 WH, 3 WM |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 5 | Memory word address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory completes request this cycle |
| mem_rdata | input | 8 | Memory read byte, valid with ready |

## Verification
A wrong tag, valid or dirty flag does not stay hidden. The next access to that index reports the wrong class on the done pulse, which comes two cycles after acceptance on a hit. The same fault also shows up on the memory port as a missing or extra request: a write-back that never happens, or a fill where none should occur. A wrong stored byte surfaces in one of two places: in the returned data of the next read hit, or in the write-back data when the line is evicted. Every memory transaction is compared in order against a reference model, and the whole memory image is compared at the end, so stale or misplaced write-backs are caught even when no read returns them.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    localparam int TAG_W  = 2;
    localparam int IDX_W  = 3;
    localparam int DATA_W = 8;
    localparam int OP_W   = 4;
    localparam int ADDR_W = TAG_W + IDX_W;
    localparam int LINES  = 1 << IDX_W;

    localparam logic [OP_W-1:0] OP_RD = 4'h5;
    localparam logic [OP_W-1:0] OP_WR = 4'h6;

    typedef enum logic [1:0] {
        HIT_RD  = 2'd0,
        MISS_RD = 2'd1,
        HIT_WR  = 2'd2,
        MISS_WR = 2'd3
    } kind_e;

    typedef struct packed {
        logic              is_wr;
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W];
    endfunction

endpackage

// File: rtl/wbc_line_store.sv
module wbc_line_store
    import wbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output line_t            rd_line,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_t            wr_line
);

    line_t            lines [LINES];
    logic [LINES-1:0] valid_bits;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lines[g].valid <= 1'b0;
                lines[g].dirty <= 1'b0;
                lines[g].tag   <= '0;
                lines[g].data  <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                lines[g] <= wr_line;
            end
        end
        assign valid_bits[g] = lines[g].valid;
    end

    assign rd_line = lines[rd_idx];

    // R8: right after reset every line is invalid
    p_cold_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (valid_bits == '0));

endmodule

// File: rtl/wbc_fsm.sv
module wbc_fsm
    import wbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic [OP_W-1:0]   cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output kind_e             cpu_kind,
    output logic [IDX_W-1:0]  rd_idx,
    input  line_t             rd_line,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output line_t             wr_line,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);

    typedef enum logic [2:0] {S_IDLE, S_LOOK, S_EVICT, S_FILL, S_RESP} state_e;

    state_e            state;
    cmd_t              cmd_q;
    kind_e             kind_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept, hit, victim_dirty;

    assign accept       = (state == S_IDLE) && cpu_valid &&
                          (cpu_op == OP_RD || cpu_op == OP_WR);
    assign rd_idx       = cmd_q.idx;
    assign hit          = rd_line.valid && (rd_line.tag == cmd_q.tag);
    assign victim_dirty = rd_line.valid && rd_line.dirty;

    // memory side
    assign mem_req   = (state == S_EVICT) || (state == S_FILL);
    assign mem_we    = (state == S_EVICT);
    assign mem_addr  = (state == S_EVICT) ? {rd_line.tag, cmd_q.idx}
                                          : {cmd_q.tag, cmd_q.idx};
    assign mem_wdata = rd_line.data;

    // line update
    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = cmd_q.idx;
        wr_line = '{valid: 1'b1, dirty: 1'b1, tag: cmd_q.tag, data: cmd_q.data};
        unique case (state)
            S_LOOK:  wr_en = cmd_q.is_wr && (hit || !victim_dirty);
            S_EVICT: wr_en = cmd_q.is_wr && mem_ready;
            S_FILL: begin
                wr_en         = mem_ready;
                wr_line.dirty = 1'b0;
                wr_line.data  = mem_rdata;
            end
            default: wr_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cmd_q   <= '0;
            kind_q  <= HIT_RD;
            rdata_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (accept) begin
                    cmd_q <= '{is_wr: (cpu_op == OP_WR), tag: tag_of(cpu_addr),
                               idx: idx_of(cpu_addr), data: cpu_wdata};
                    state <= S_LOOK;
                end
                S_LOOK: begin
                    if (hit) begin
                        kind_q  <= cmd_q.is_wr ? HIT_WR : HIT_RD;
                        rdata_q <= cmd_q.is_wr ? cmd_q.data : rd_line.data;
                        state   <= S_RESP;
                    end else if (victim_dirty) begin
                        state <= S_EVICT;
                    end else if (cmd_q.is_wr) begin
                        kind_q  <= MISS_WR;
                        rdata_q <= cmd_q.data;
                        state   <= S_RESP;
                    end else begin
                        state <= S_FILL;
                    end
                end
                S_EVICT: if (mem_ready) begin
                    if (cmd_q.is_wr) begin
                        kind_q  <= MISS_WR;
                        rdata_q <= cmd_q.data;
                        state   <= S_RESP;
                    end else begin
                        state <= S_FILL;
                    end
                end
                S_FILL: if (mem_ready) begin
                    kind_q  <= MISS_RD;
                    rdata_q <= mem_rdata;
                    state   <= S_RESP;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign cpu_busy  = (state != S_IDLE);
    assign cpu_done  = (state == S_RESP);
    assign cpu_rdata = rdata_q;
    assign cpu_kind  = kind_q;

    // R2/R3: a lookup that hits never reaches the memory port
    p_hit_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOOK && hit) |=> (!mem_req && cpu_done));

    // R6: a write miss on a clean line completes without memory
    p_wmiss_no_read_r6: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOOK && cmd_q.is_wr && !hit && !victim_dirty) |=> (!mem_req && cpu_done));

    // R5: a finished write-back of a read miss is followed by the fill read
    p_fill_after_evict_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ready && !cmd_q.is_wr) |=> (mem_req && !mem_we));

    // R6: a write miss never issues a memory read
    p_no_read_on_write_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !cmd_q.is_wr);

endmodule

// File: rtl/wbc_top.sv
module wbc_top
    import wbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic [OP_W-1:0]   cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [1:0]        cpu_kind,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic [IDX_W-1:0] rd_idx, wr_idx;
    line_t            rd_line, wr_line;
    logic             wr_en;
    kind_e            kind;

    wbc_line_store i_store (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (rd_idx),
        .rd_line (rd_line),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_line (wr_line)
    );

    wbc_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .cpu_valid (cpu_valid),
        .cpu_op    (cpu_op),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_busy  (cpu_busy),
        .cpu_done  (cpu_done),
        .cpu_rdata (cpu_rdata),
        .cpu_kind  (kind),
        .rd_idx    (rd_idx),
        .rd_line   (rd_line),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_line   (wr_line),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata)
    );

    assign cpu_kind = kind;

    // R9: an unanswered request keeps its contents
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));

    // R10: done is a single-cycle pulse inside the busy window
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    p_done_busy_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> cpu_busy);

endmodule

// File: tb/test_wbc_top.sv
module test_wbc_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_valid = 1'b0;
    logic [3:0] cpu_op = 4'h0;
    logic [4:0] cpu_addr = 5'h0;
    logic [7:0] cpu_wdata = 8'h0;
    logic       cpu_busy, cpu_done, mem_req, mem_we;
    logic [7:0] cpu_rdata, mem_wdata;
    logic [1:0] cpu_kind;
    logic [4:0] mem_addr;
    logic       mem_ready = 1'b0;
    logic [7:0] mem_rdata = 8'h0;

    always #2.5 clk = ~clk;

    wbc_top i_wbc_top (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .cpu_kind(cpu_kind),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    typedef struct {
        logic [1:0] kind;
        bit         is_rd;
        logic [7:0] data;
        string      req;
    } resp_t;

    typedef struct {
        bit         we;
        logic [4:0] addr;
        logic [7:0] data;
    } mtx_t;

    resp_t exp_resp[$];
    mtx_t  exp_mem[$];

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit ended   = 0;

    // reference state
    logic [7:0] bmem    [32];
    logic [7:0] ref_mem [32];
    bit         m_valid [8];
    bit         m_dirty [8];
    logic [1:0] m_tag   [8];
    logic [7:0] m_data  [8];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // memory responder with varying latency (R9)
    int  n_txn = 0;
    int  wait_left = 0;
    bit  txn_open = 0;
    always @(negedge clk) begin
        if (rst) begin
            mem_ready = 1'b0;
            txn_open  = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
            txn_open  = 0;
        end else if (mem_req) begin
            if (!txn_open) begin
                txn_open  = 1;
                wait_left = (n_txn * 3) % 4;
                n_txn++;
            end
            if (wait_left == 0) begin
                if (exp_mem.size() == 0) begin
                    check(0, "R2", "unexpected memory access at", {3'b0, mem_addr}, 8'h00);
                end else begin
                    mtx_t e;
                    e = exp_mem.pop_front();
                    check(mem_we == e.we, "R5", "memory direction", {7'b0, mem_we}, {7'b0, e.we});
                    check(mem_addr == e.addr, "R9", "memory address", {3'b0, mem_addr}, {3'b0, e.addr});
                    if (e.we)
                        check(mem_wdata == e.data, "R5", "write-back data", mem_wdata, e.data);
                end
                if (mem_we) bmem[mem_addr] = mem_wdata;
                else        mem_rdata = bmem[mem_addr];
                mem_ready = 1'b1;
            end else begin
                wait_left--;
            end
        end
    end

    // monitor: compare completions against the scoreboard
    always @(negedge clk) begin
        if (!rst && cpu_done) begin
            if (exp_resp.size() == 0) begin
                check(0, "R10", "unexpected done, kind", {6'b0, cpu_kind}, 8'h00);
            end else begin
                resp_t e;
                e = exp_resp.pop_front();
                check(cpu_kind == e.kind, e.req, "access kind", {6'b0, cpu_kind}, {6'b0, e.kind});
                if (e.is_rd)
                    check(cpu_rdata == e.data, e.req, "read data", cpu_rdata, e.data);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000 && !ended) begin
            ended = 1;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 60000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // driver: update the reference model, push expectations, drive the port
    task automatic issue(input logic [3:0] op, input logic [4:0] a,
                         input logic [7:0] d, input bit poke);
        logic [2:0] ix;
        logic [1:0] tg;
        bit         legal, hit;
        resp_t      r;
        ix    = a[2:0];                         // R1 index
        tg    = a[4:3];                         // R1 tag
        legal = (op == 4'h5) || (op == 4'h6);   // R7 codes
        if (legal) begin
            hit = m_valid[ix] && (m_tag[ix] == tg);
            r.is_rd = (op == 4'h5);
            if (hit) begin
                r.kind = r.is_rd ? 2'd0 : 2'd2;
                r.req  = r.is_rd ? "R2" : "R3";
                if (r.is_rd) r.data = m_data[ix];
                else begin r.data = d; m_data[ix] = d; m_dirty[ix] = 1; end
            end else begin
                if (m_valid[ix] && m_dirty[ix]) begin
                    exp_mem.push_back('{1'b1, {m_tag[ix], ix}, m_data[ix]});
                    ref_mem[{m_tag[ix], ix}] = m_data[ix];
                end
                m_valid[ix] = 1;
                m_tag[ix]   = tg;
                if (r.is_rd) begin
                    exp_mem.push_back('{1'b0, a, 8'h00});
                    r.kind = 2'd1; r.req = "R4"; r.data = ref_mem[a];
                    m_data[ix] = ref_mem[a]; m_dirty[ix] = 0;
                end else begin
                    r.kind = 2'd3; r.req = "R6"; r.data = d;
                    m_data[ix] = d; m_dirty[ix] = 1;
                end
            end
            exp_resp.push_back(r);
        end
        @(negedge clk);
        while (cpu_busy) @(negedge clk);
        cpu_valid = 1'b1; cpu_op = op; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        if (poke) begin
            // R10: a second command while busy must be refused
            cpu_op = 4'h6; cpu_addr = a ^ 5'h08; cpu_wdata = 8'hEE;
            @(negedge clk);
        end
        cpu_valid = 1'b0;
        if (legal) begin
            while (cpu_busy) @(negedge clk);
        end else begin
            for (int k = 0; k < 4; k++) begin
                check(!cpu_busy && !cpu_done && !mem_req, "R7", "dropped code caused activity",
                      {5'b0, cpu_busy, cpu_done, mem_req}, 8'h00);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        logic [7:0] lfsr;
        for (int i = 0; i < 32; i++) begin
            bmem[i]    = 8'h40 + 8'(i);
            ref_mem[i] = 8'h40 + 8'(i);
        end
        for (int i = 0; i < 8; i++) begin
            m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0; m_data[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state at the ports
        check(!cpu_busy && !cpu_done && !mem_req, "R8", "idle after reset",
              {5'b0, cpu_busy, cpu_done, mem_req}, 8'h00);

        issue(4'h5, 5'h17, 8'h00, 0);   // R8/R4: cold read miss, line 7 tag 2
        issue(4'h5, 5'h17, 8'h00, 0);   // R2: read hit
        issue(4'h5, 5'h0F, 8'h00, 0);   // R1: same index, other tag -> miss
        issue(4'h6, 5'h09, 8'h55, 0);   // R6: write miss, clean line
        issue(4'h6, 5'h09, 8'h56, 0);   // R3: write hit
        issue(4'h5, 5'h09, 8'h00, 0);   // R2: hit returns written byte
        issue(4'h6, 5'h11, 8'hAA, 0);   // R5/R6: write miss evicts dirty 0x09
        issue(4'h6, 5'h02, 8'h33, 0);   // R6
        issue(4'h5, 5'h1A, 8'h00, 0);   // R5/R4: write-back then fill
        issue(4'h6, 5'h1A, 8'h77, 0);   // R3
        issue(4'h7, 5'h1A, 8'h00, 0);   // R7: dropped code
        issue(4'h0, 5'h1A, 8'h11, 0);   // R7: dropped code
        issue(4'h5, 5'h1A, 8'h00, 0);   // R7: line untouched, still 0x77
        issue(4'h5, 5'h04, 8'h00, 1);   // R10: poke while busy
        issue(4'h5, 5'h0C, 8'h00, 0);   // R10: poked write was not applied

        lfsr = 8'hA5;
        for (int n = 0; n < 80; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            issue(lfsr[7] ? 4'h6 : 4'h5, lfsr[4:0], lfsr ^ 8'h3C, n % 9 == 0);
        end

        repeat (10) @(negedge clk);
        check(exp_resp.size() == 0, "R10", "missing completions", 8'(exp_resp.size()), 8'h00);
        check(exp_mem.size() == 0, "R5", "missing memory accesses", 8'(exp_mem.size()), 8'h00);
        for (int i = 0; i < 32; i++)
            check(bmem[i] == ref_mem[i], "R5", $sformatf("memory word %0h", i), bmem[i], ref_mem[i]);

        ended = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule